// File: doc/BRIEF.md
# Register-fed stream packet transmitter

This block turns a sequence of 32-bit register writes into framed packets on a stream master port. Software first pushes payload words one at a time into a data register, where they collect in an internal word buffer. It then writes the packet's byte count to a length register. That write is the commit point. The block checks the byte count against the number of words actually pushed since the previous commit. A match releases the words onto the stream, with TLAST on the final word. A mismatch throws the words away and flags an error.

Software reads a vacancy register to learn how many more words the buffer will take. A flush happens only when a fixed key value is written to the reset register. Four transmit events are recorded in a write-one-to-clear status register: transmit complete, overrun, length mismatch and flush done. An enable register masks these events onto a single interrupt line.

The register side is a plain single-cycle strobe bus. Read data is registered and appears one clock after the address. The buffer depth `DEPTH` must be a power of two greater than 4. The usable capacity is `DEPTH-4` words.

Top module: `pkt_tx_regs`

## Requirements
- R1: After the synchronous reset, the vacancy register reads DEPTH-4, the status and enable registers read 0, and m_tvalid and irq are 0.
- R2: Each data write that is accepted lowers the vacancy by one. A successful commit followed by full transmission restores it.
- R3: A data write made while the vacancy is 0 sets status bit 28 (overrun) and is dropped. The word never appears on the stream and the vacancy stays 0.
- R4: Pushed words stay off the stream until a matching length write arrives. They then leave in push order, with m_tlast set on the last word only.
- R5: Some length writes are bad: a byte count that is zero, that is not a multiple of 4, or whose count divided by 4 differs from the number of words pushed since the last commit. A bad write sets status bit 25 (mismatch), launches nothing and discards the pending words, so the vacancy comes back.
- R6: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast hold their values.
- R7: Status bit 27 (transmit complete) is set when the word carrying m_tlast is accepted.
- R8: Writing 0xA5 to the reset register empties the buffer, drops pending words and any word held on the stream port, and sets status bit 24 (flush done). Any other value written there has no effect.
- R9: Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear. Only bits 31 to 19 of the status and enable registers exist; the lower bits read 0.
- R10: irq is 1 one cycle after any status bit and its enable bit are both 1, and returns to 0 once that no longer holds.
- R11: The offsets are status 0x00, enable 0x04, reset 0x08, vacancy 0x0C (read), data 0x10 (write) and length 0x14 (write). reg_rdata shows the register addressed in the previous cycle, and other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered from the previous cycle's address |
| m_tdata | output | 32 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the sink |
| m_tlast | output | 1 | Marks the final word of a packet |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The bench fills the buffer exactly to capacity and pushes one word more. A design with an off-by-one in its vacancy would either accept that word and send it, or refuse a word it should take. Length writes that disagree with the pushed count, including a zero count with nothing pushed, must leave the stream silent and the vacancy restored. A design that launched anyway would emit a stray packet, and one that kept the words would report lost vacancy. The sink is also stalled with a word on the port, to catch data that changes under backpressure. A flush with the wrong key and a flush with the right key are both tried: a design that ignored the key would lose pending words, and one that kept its pending count would accept a stale length afterwards.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int WORD_W = 32;

  localparam logic [5:0] OFS_STAT  = 6'h00;
  localparam logic [5:0] OFS_ENAB  = 6'h04;
  localparam logic [5:0] OFS_FLUSH = 6'h08;
  localparam logic [5:0] OFS_VAC   = 6'h0C;
  localparam logic [5:0] OFS_DATA  = 6'h10;
  localparam logic [5:0] OFS_LEN   = 6'h14;

  localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;
  localparam logic [31:0] IMPL_MASK = 32'hFFF8_0000;

  localparam int B_OVR  = 28;
  localparam int B_DONE = 27;
  localparam int B_MISM = 25;
  localparam int B_FLSH = 24;
endpackage

// File: rtl/pkt_tx_buf.sv
module pkt_tx_buf
  import pkt_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CAP   = DEPTH - 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              commit,
  input  logic              discard,
  input  logic              flush,
  output logic [AW:0]       used,
  output logic [AW:0]       pend,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  last_q;
  logic [AW:0]       wr_ptr, cmt_ptr, rd_ptr;
  logic              load;

  assign used = wr_ptr - rd_ptr;
  assign pend = wr_ptr - cmt_ptr;
  assign load = (!m_tvalid || m_tready) && (rd_ptr != cmt_ptr) && !flush;

  // storage and output word, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_data;
    if (load) m_tdata <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
    end else if (push) begin
      last_q[wr_ptr[AW-1:0]] <= 1'b0;
    end else if (commit) begin
      last_q[wr_ptr[AW-1:0] - 1'b1] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr   <= '0;
      cmt_ptr  <= '0;
      rd_ptr   <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else begin
      if (push)         wr_ptr  <= wr_ptr + 1'b1;
      else if (discard) wr_ptr  <= cmt_ptr;
      if (commit)       cmt_ptr <= wr_ptr;
      if (load) begin
        rd_ptr   <= rd_ptr + 1'b1;
        m_tvalid <= 1'b1;
        m_tlast  <= last_q[rd_ptr[AW-1:0]];
      end else if (m_tready) begin
        m_tvalid <= 1'b0;
      end
    end
  end

  // R6
  tvalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready && !flush) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used <= (AW+1)'(CAP));
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (used == '0 && pend == '0 && !m_tvalid));
endmodule

// File: rtl/pkt_tx_stat.sv
module pkt_tx_stat
  import pkt_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_vec,
  input  logic              clr_wen,
  input  logic              ena_wen,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] stat,
  output logic [WORD_W-1:0] enab,
  output logic              irq
);
  logic [WORD_W-1:0] clr_vec;
  assign clr_vec = clr_wen ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      enab <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= ((stat & ~clr_vec) | set_vec) & IMPL_MASK;
      if (ena_wen) enab <= wdata & IMPL_MASK;
      irq  <= |(stat & enab);
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_vec[B_DONE] |=> stat[B_DONE]);
endmodule

// File: rtl/pkt_tx_regs.sv
module pkt_tx_regs
  import pkt_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wen,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CAP = DEPTH - 4;

  logic [AW:0]  used, pend, vac;
  logic [31:0]  stat, enab, set_vec;
  logic         wr_data, push, ovr, wr_len, len_ok, commit, discard, flush;

  assign vac     = (AW+1)'(CAP) - used;
  assign wr_data = reg_wen && reg_addr == OFS_DATA;
  assign push    = wr_data && vac != '0;
  assign ovr     = wr_data && vac == '0;
  assign wr_len  = reg_wen && reg_addr == OFS_LEN;
  assign len_ok  = reg_wdata[1:0] == 2'b00 && pend != '0 &&
                   (reg_wdata >> 2) == 32'(pend);
  assign commit  = wr_len && len_ok;
  assign discard = wr_len && !len_ok;
  assign flush   = reg_wen && reg_addr == OFS_FLUSH && reg_wdata == FLUSH_KEY;

  always_comb begin
    set_vec         = '0;
    set_vec[B_OVR]  = ovr;
    set_vec[B_DONE] = m_tvalid && m_tready && m_tlast;
    set_vec[B_MISM] = discard;
    set_vec[B_FLSH] = flush;
  end

  pkt_tx_buf #(.DEPTH(DEPTH), .CAP(CAP)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_data(reg_wdata),
    .commit(commit), .discard(discard), .flush(flush),
    .used(used), .pend(pend), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .m_tready(m_tready)
  );

  pkt_tx_stat u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_wen(reg_wen && reg_addr == OFS_STAT),
    .ena_wen(reg_wen && reg_addr == OFS_ENAB),
    .wdata(reg_wdata), .stat(stat), .enab(enab), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        OFS_STAT: reg_rdata <= stat;
        OFS_ENAB: reg_rdata <= enab;
        OFS_VAC:  reg_rdata <= 32'(vac);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R3
  overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |=> (stat[B_OVR] && $stable(used)));
  // R5
  mismatch_flag_chk: assert property (@(posedge clk) disable iff (rst)
    discard |=> (stat[B_MISM] && pend == '0));
endmodule

// File: tb/pkt_tx_regs_bench.sv
`timescale 1ns/1ps
module pkt_tx_regs_bench;
  localparam int DEPTH = 16;
  localparam int CAP   = DEPTH - 4;

  logic clk = 0, rst = 1, reg_wen = 0, m_tready = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, m_tdata;
  logic m_tvalid, m_tlast, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] rx_d [64];
  bit          rx_l [64];
  int          rx_n = 0;

  always #10 clk = ~clk;

  pkt_tx_regs #(.DEPTH(DEPTH)) u_pkt_tx_regs (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast), .irq(irq)
  );

  // stream monitor: values seen before the edge are the ones handed over
  always @(posedge clk)
    if (!rst && m_tvalid && m_tready && rx_n < 64) begin
      rx_d[rx_n] = m_tdata;
      rx_l[rx_n] = m_tlast;
      rx_n++;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_wen = 0; reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h0C, v); chk(v == CAP, "R1 vacancy", v, CAP);
    rd(6'h00, v); chk(v == 0, "R1 status", v, 0);
    rd(6'h04, v); chk(v == 0, "R1 enable", v, 0);
    rd(6'h18, v); chk(v == 0, "R11 unmapped offset", v, 0);
    chk(!m_tvalid && !irq, "R1 tvalid/irq", {m_tvalid, irq}, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    m_tready = 1; rx_n = 0;
    for (int i = 0; i < 3; i++) wr(6'h10, 32'hA000_0000 + i);
    rd(6'h0C, v); chk(v == CAP - 3, "R2 vacancy after 3 pushes", v, CAP - 3);
    idle(4); chk(rx_n == 0, "R4 held before length", rx_n, 0);
    wr(6'h14, 12); idle(8);
    chk(rx_n == 3, "R4 word count", rx_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk(rx_d[i] == 32'hA000_0000 + i, "R4 data order", rx_d[i], 32'hA000_0000 + i);
      chk(rx_l[i] == (i == 2), "R4 tlast position", rx_l[i], (i == 2));
    end
    rd(6'h00, v); chk(v[27], "R7 complete bit", v, 32'h0800_0000);
    rd(6'h0C, v); chk(v == CAP, "R2 vacancy restored", v, CAP);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); chk(v == 0, "R9 write-one clear", v, 0);
  endtask

  task automatic t_mismatch;
    logic [31:0] v;
    m_tready = 1; rx_n = 0;
    wr(6'h10, 32'h1); wr(6'h10, 32'h2);
    wr(6'h14, 12); idle(6);
    rd(6'h00, v); chk(v == 32'h0200_0000, "R5 mismatch bit", v, 32'h0200_0000);
    rd(6'h0C, v); chk(v == CAP, "R5 words discarded", v, CAP);
    chk(rx_n == 0, "R5 nothing launched", rx_n, 0);
    wr(6'h00, 32'h0200_0000);
    wr(6'h14, 0); idle(4);
    rd(6'h00, v); chk(v == 32'h0200_0000, "R5 zero length, no words", v, 32'h0200_0000);
    wr(6'h10, 32'h5);
    wr(6'h00, 32'h0200_0000);
    wr(6'h14, 6); idle(4);
    rd(6'h00, v); chk(v == 32'h0200_0000, "R5 unaligned length", v, 32'h0200_0000);
    chk(rx_n == 0, "R5 still nothing launched", rx_n, 0);
    wr(6'h00, 32'hFFFF_FFFF);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    m_tready = 0; rx_n = 0;
    for (int i = 0; i < CAP; i++) wr(6'h10, 32'hB000_0000 + i);
    rd(6'h0C, v); chk(v == 0, "R2 vacancy at capacity", v, 0);
    wr(6'h10, 32'hDEAD_BEEF);
    rd(6'h0C, v); chk(v == 0, "R3 vacancy stays 0", v, 0);
    rd(6'h00, v); chk(v == 32'h1000_0000, "R3 overrun bit", v, 32'h1000_0000);
    wr(6'h14, CAP * 4); m_tready = 1; idle(CAP + 8);
    chk(rx_n == CAP, "R3 dropped word absent", rx_n, CAP);
    chk(rx_d[CAP-1] == 32'hB000_0000 + CAP - 1, "R3 last word", rx_d[CAP-1], 32'hB000_0000 + CAP - 1);
    chk(rx_l[CAP-1], "R4 tlast at capacity", rx_l[CAP-1], 1);
    wr(6'h00, 32'hFFFF_FFFF);
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    m_tready = 0; rx_n = 0;
    wr(6'h10, 32'hC1); wr(6'h10, 32'hC2); wr(6'h14, 8); idle(3);
    first = m_tdata;
    chk(m_tvalid && first == 32'hC1 && !m_tlast, "R6 word presented", first, 32'hC1);
    idle(5);
    chk(m_tvalid && m_tdata == first && !m_tlast, "R6 held under stall", m_tdata, first);
    m_tready = 1; idle(4);
    chk(rx_n == 2 && rx_d[1] == 32'hC2 && rx_l[1], "R6 drained after stall", rx_d[1], 32'hC2);
    wr(6'h00, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk(v == 32'hFFF8_0000, "R9 enable implemented bits", v, 32'hFFF8_0000);
    wr(6'h04, 32'h0800_0000);
    idle(2); chk(!irq, "R10 irq low when clear", irq, 0);
    m_tready = 1;
    wr(6'h10, 32'h77); wr(6'h14, 4); idle(6);
    chk(irq, "R10 irq on enabled complete", irq, 1);
    wr(6'h04, 32'h0); idle(2);
    chk(!irq, "R10 irq masked", irq, 0);
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h04, 32'h0800_0000); idle(2);
    chk(!irq, "R10 irq after clear", irq, 0);
    wr(6'h04, 0);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    m_tready = 0; rx_n = 0;
    wr(6'h10, 32'hE1); wr(6'h14, 4); idle(3);
    wr(6'h10, 32'hE2); wr(6'h10, 32'hE3);
    wr(6'h08, 32'h0000_0012);
    rd(6'h0C, v); chk(v == CAP - 2, "R8 wrong key ignored", v, CAP - 2);
    chk(m_tvalid, "R8 wrong key keeps stream word", m_tvalid, 1);
    wr(6'h08, 32'h0000_00A5);
    rd(6'h0C, v); chk(v == CAP, "R8 buffer emptied", v, CAP);
    chk(!m_tvalid, "R8 stream word dropped", m_tvalid, 0);
    rd(6'h00, v); chk(v == 32'h0100_0000, "R8 flush done bit", v, 32'h0100_0000);
    m_tready = 1;
    wr(6'h14, 8); idle(5);
    rd(6'h00, v); chk(v[25], "R8 pending count cleared", v, 32'h0300_0000);
    chk(rx_n == 0, "R8 no stale launch", rx_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_basic;
    t_mismatch;
    t_overrun;
    t_backpressure;
    t_irq;
    t_flush;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule